// File: doc/BRIEF.md
# Bit-Serial Distributed-Arithmetic FIR Filter

This block is a finite impulse response filter that uses no multipliers. Each tap holds one past input sample. The coefficients are folded into a partial-sum table with one entry per combination of taps. A sample is consumed one bit per clock, least significant bit first. On each bit cycle, the bit of that weight from every tap forms the table address. The table entry that comes out is shifted to the weight of the bit and added to an accumulator. On the cycle for the sign bit, the entry is subtracted instead, so inputs in two's complement come out right.

Coefficients are written one at a time through a load port. Every accepted write restarts a built-in table builder. The builder computes one table entry per clock from the stored coefficients. Until the table is complete, the filter refuses new samples. Each result is presented with a one-clock valid pulse. The filter can take the next sample on the clock after that pulse.

Top module: `dafir_serial`

## Requirements
- R1: The result equals the exact signed sum over all taps of coefficient(t) times sample(t). Tap 0 is the newest accepted sample and tap NTAPS-1 the oldest. Samples and coefficients are two's complement, and the result is OUT_W = CW + clog2(NTAPS) + DW bits wide.
- R2: out_valid rises exactly DW clocks after the clock edge that accepts a sample, and it stays high for a single clock.
- R3: in_ready is low from the clock after an accepted sample until out_valid is high. A sample offered in that interval is ignored and does not enter the tap line. in_ready is high again in the cycle where out_valid is high.
- R4: coef_idx selects the tap whose coefficient coef_val replaces, with index 0 applying to the newest sample. After each accepted write, the table is rebuilt one entry per clock. in_ready goes high exactly 2^NTAPS clocks after the last write edge.
- R5: A sample offered while the table is being rebuilt is ignored. A sample offered in the same cycle as a coefficient write is also ignored, because the write takes priority.
- R6: coef_ready is low while a sample is being processed. A coefficient write in that interval is ignored: the running and later results use the old coefficients, and no rebuild starts.
- R7: After reset, out_valid is 0, in_ready and coef_ready are 1, all coefficients and table entries are zero, and the tap line holds zeros.
- R8: Table entry k holds the sum of the coefficients of the taps whose bit is set in k. On the final (sign) bit cycle, the shifted entry is subtracted rather than added.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | A sample is offered |
| in_sample | input | DW | Two's-complement input sample |
| in_ready | output | 1 | Filter is idle with a complete table |
| coef_we | input | 1 | Coefficient write request |
| coef_idx | input | clog2(NTAPS) | Tap selected by the write |
| coef_val | input | CW | Two's-complement coefficient |
| coef_ready | output | 1 | Coefficient writes are accepted |
| out_valid | output | 1 | One-clock pulse marking a new result |
| out_result | output | OUT_W | Signed filter result |

## Verification
The bench builds the filter with four taps and 8-bit samples and coefficients. With these values the table has 16 entries, the rebuild takes 16 clocks, and each sample takes 8 clocks. The whole product range is within reach, including -128 in every tap against -128 coefficients, which drives the accumulator close to its largest value. Fixed vectors cover the impulse response and the sign-bit subtraction. Random samples are compared against a direct multiply-accumulate model. Directed cases offer samples and coefficient writes while the filter is busy or rebuilding, and check that they change nothing.

// File: rtl/dafir_pkg.sv
`timescale 1ns/1ps
package dafir_pkg;
  // Coarse activity of the filter, exposed for assertions
  typedef enum logic [1:0] {
    CTL_IDLE  = 2'd0,
    CTL_BUILD = 2'd1,
    CTL_RUN   = 2'd2
  } ctl_state_t;
endpackage

// File: rtl/dafir_tapline.sv
`timescale 1ns/1ps
module dafir_tapline #(
  parameter int NTAPS = 4,
  parameter int DW    = 8,
  localparam int BW   = (DW > 1) ? $clog2(DW) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [DW-1:0]    din,
  input  logic [BW-1:0]    bit_sel,
  output logic [NTAPS-1:0] column
);
  logic [DW-1:0] taps [NTAPS];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NTAPS; i++) taps[i] <= '0;
    end else if (load) begin
      taps[0] <= din;
      for (int i = 1; i < NTAPS; i++) taps[i] <= taps[i-1];
    end
  end

  // One bit of equal weight from every tap forms the table address
  for (genvar g = 0; g < NTAPS; g++) begin : g_col
    assign column[g] = taps[g][bit_sel];
  end
endmodule

// File: rtl/dafir_table.sv
`timescale 1ns/1ps
module dafir_table #(
  parameter int NTAPS = 4,
  parameter int CW    = 8,
  localparam int IW      = (NTAPS > 1) ? $clog2(NTAPS) : 1,
  localparam int TW      = CW + IW,
  localparam int ENTRIES = 1 << NTAPS
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 wr_en,
  input  logic [IW-1:0]        wr_idx,
  input  logic [CW-1:0]        wr_data,
  input  logic [NTAPS-1:0]     rd_addr,
  output logic signed [TW-1:0] rd_data,
  output logic                 building
);
  logic signed [CW-1:0] coef [NTAPS];
  logic signed [TW-1:0] mem  [ENTRIES];
  logic [NTAPS-1:0]     build_cnt;
  logic                 build_last;

  // Sum of the coefficients selected by the set bits of sel (R8)
  function automatic logic signed [TW-1:0] partial_sum(input logic [NTAPS-1:0] sel);
    logic signed [TW-1:0] s;
    s = '0;
    for (int i = 0; i < NTAPS; i++)
      if (sel[i]) s = s + TW'(coef[i]);
    return s;
  endfunction

  assign build_last = (build_cnt == {NTAPS{1'b1}});

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NTAPS; i++)   coef[i] <= '0;
      for (int k = 0; k < ENTRIES; k++) mem[k]  <= '0;
      build_cnt <= '0;
      building  <= 1'b0;
    end else if (wr_en) begin
      coef[wr_idx] <= wr_data;
      build_cnt    <= '0;
      building     <= 1'b1;
    end else if (building) begin
      mem[build_cnt] <= partial_sum(build_cnt);
      build_cnt      <= build_cnt + 1'b1;
      if (build_last) building <= 1'b0;
    end
  end

  assign rd_data = mem[rd_addr];

  AST_WRITE_RESTARTS: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> (building && build_cnt == '0)); // R4
  AST_BUILD_CONTINUES: assert property (@(posedge clk) disable iff (!rst_n)
    (building && !wr_en && !build_last) |=> building); // R4
endmodule

// File: rtl/dafir_shacc.sv
`timescale 1ns/1ps
module dafir_shacc #(
  parameter int DW = 8,
  parameter int TW = 10,
  localparam int AW = TW + DW,
  localparam int BW = (DW > 1) ? $clog2(DW) : 1
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 start,
  input  logic signed [TW-1:0] term,
  output logic [BW-1:0]        bit_idx,
  output logic                 busy,
  output logic                 done,
  output logic signed [AW-1:0] result
);
  logic signed [AW-1:0] acc;
  logic signed [AW-1:0] acc_next;
  logic                 sign_cyc;

  // Table entry weighted by the current bit; subtracted on the sign bit (R8)
  function automatic logic signed [AW-1:0] weigh(input logic signed [TW-1:0] t,
                                                 input logic [BW-1:0] b);
    logic signed [AW-1:0] ext;
    ext = AW'(t);
    return ext <<< b;
  endfunction

  assign sign_cyc = (bit_idx == BW'(DW - 1));
  assign acc_next = sign_cyc ? (acc - weigh(term, bit_idx))
                             : (acc + weigh(term, bit_idx));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc     <= '0;
      bit_idx <= '0;
      busy    <= 1'b0;
      done    <= 1'b0;
      result  <= '0;
    end else begin
      done <= 1'b0;
      if (start) begin
        acc     <= '0;
        bit_idx <= '0;
        busy    <= 1'b1;
      end else if (busy) begin
        acc <= acc_next;
        if (sign_cyc) begin
          busy   <= 1'b0;
          done   <= 1'b1;
          result <= acc_next;
        end else begin
          bit_idx <= bit_idx + 1'b1;
        end
      end
    end
  end

  AST_START_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> (busy && acc == '0 && bit_idx == '0)); // R1
  AST_DONE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy); // R2
endmodule

// File: rtl/dafir_serial.sv
`timescale 1ns/1ps
module dafir_serial #(
  parameter int NTAPS = 4,
  parameter int DW    = 8,
  parameter int CW    = 8,
  localparam int IW    = (NTAPS > 1) ? $clog2(NTAPS) : 1,
  localparam int TW    = CW + IW,
  localparam int OUT_W = TW + DW,
  localparam int BW    = (DW > 1) ? $clog2(DW) : 1
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    in_valid,
  input  logic [DW-1:0]           in_sample,
  output logic                    in_ready,
  input  logic                    coef_we,
  input  logic [IW-1:0]           coef_idx,
  input  logic [CW-1:0]           coef_val,
  output logic                    coef_ready,
  output logic                    out_valid,
  output logic signed [OUT_W-1:0] out_result
);
  import dafir_pkg::*;

  logic                 busy;
  logic                 building;
  logic                 accept;
  logic                 coef_accept;
  logic [BW-1:0]        bit_idx;
  logic [NTAPS-1:0]     column;
  logic signed [TW-1:0] term;
  ctl_state_t           ctl_state;

  assign in_ready    = !busy && !building;
  assign coef_ready  = !busy;
  assign coef_accept = coef_we && coef_ready;
  assign accept      = in_valid && in_ready && !coef_we;   // write wins (R5)
  assign ctl_state   = building ? CTL_BUILD : (busy ? CTL_RUN : CTL_IDLE);

  dafir_tapline #(.NTAPS(NTAPS), .DW(DW)) u_taps (
    .clk(clk), .rst_n(rst_n), .load(accept), .din(in_sample),
    .bit_sel(bit_idx), .column(column)
  );

  dafir_table #(.NTAPS(NTAPS), .CW(CW)) u_table (
    .clk(clk), .rst_n(rst_n), .wr_en(coef_accept), .wr_idx(coef_idx),
    .wr_data(coef_val), .rd_addr(column), .rd_data(term), .building(building)
  );

  dafir_shacc #(.DW(DW), .TW(TW)) u_acc (
    .clk(clk), .rst_n(rst_n), .start(accept), .term(term),
    .bit_idx(bit_idx), .busy(busy), .done(out_valid), .result(out_result)
  );

  AST_OUT_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |=> !out_valid); // R2
  AST_ACCEPT_BLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> (!in_ready && ctl_state == CTL_RUN)); // R3
  AST_DONE_FREES: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> (ctl_state == CTL_IDLE)); // R3
  AST_WRITE_REBUILDS: assert property (@(posedge clk) disable iff (!rst_n)
    coef_accept |=> (!in_ready && ctl_state == CTL_BUILD)); // R4
  AST_BUSY_HOLDS_COEF: assert property (@(posedge clk) disable iff (!rst_n)
    (coef_we && busy) |=> !building); // R6
endmodule

// File: tb/tb_dafir_serial.sv
`timescale 1ns/1ps
module tb_dafir_serial;
  localparam int NT = 4;
  localparam int DW = 8;
  localparam int CW = 8;
  localparam int OW = CW + 2 + DW;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic in_valid = 1'b0;
  logic [DW-1:0] in_sample = '0;
  logic in_ready;
  logic coef_we = 1'b0;
  logic [1:0] coef_idx = '0;
  logic [CW-1:0] coef_val = '0;
  logic coef_ready;
  logic out_valid;
  logic signed [OW-1:0] out_result;

  int tests = 0;
  int fails = 0;
  bit finished = 1'b0;
  int hist [NT];
  int cf [NT];

  localparam int VEC_X [8] = '{1, 0, 0, 0, -128, 127, -1, 10};
  localparam int VEC_Y [8] = '{3, -2, 5, 1, -384, 637, -897, 539};

  always #10 clk = ~clk;

  dafir_serial #(.NTAPS(NT), .DW(DW), .CW(CW)) dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_sample(in_sample),
    .in_ready(in_ready), .coef_we(coef_we), .coef_idx(coef_idx),
    .coef_val(coef_val), .coef_ready(coef_ready), .out_valid(out_valid),
    .out_result(out_result)
  );

  task automatic check(input int act, input int exp, input string req, input string what);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  function automatic int ref_out();
    int s = 0;
    for (int i = 0; i < NT; i++) s += cf[i] * hist[i];
    return s;
  endfunction

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic wait_ready();
    while (!in_ready) tick();
  endtask

  task automatic clear_model();
    for (int i = 0; i < NT; i++) begin
      hist[i] = 0;
      cf[i] = 0;
    end
  endtask

  // mode 0: plain; 1: hold a junk sample while busy; 2: coefficient write while busy
  task automatic run_sample(input int s, input bit use_exp, input int exp_in,
                            input string req, input int mode);
    int exp;
    wait_ready();
    in_valid = 1'b1;
    in_sample = DW'(s);
    tick();
    in_valid = 1'b0;
    for (int i = NT - 1; i > 0; i--) hist[i] = hist[i-1];
    hist[0] = s;
    exp = use_exp ? exp_in : ref_out();
    if (mode == 1) begin
      in_valid = 1'b1;
      in_sample = DW'(33);
    end
    for (int k = 1; k <= DW; k++) begin
      tick();
      if (mode == 1 && k == DW - 1) in_valid = 1'b0;
      if (mode == 2 && k == 2) begin
        check(int'(coef_ready), 0, "R6", "coef_ready while busy");
        coef_we = 1'b1; coef_idx = 2'd0; coef_val = 8'd100;
      end
      if (mode == 2 && k == 3) coef_we = 1'b0;
      if (k == 1) check(int'(in_ready), 0, "R3", "in_ready after accept");
      if (k < DW && out_valid) check(k, DW, "R2", "early out_valid");
    end
    check(int'(out_valid), 1, "R2", "out_valid at latency DW");
    check(int'(in_ready), 1, "R3", "in_ready with out_valid");
    check(int'(out_result), exp, req, "result");
    tick();
    check(int'(out_valid), 0, "R2", "out_valid one-clock pulse");
    if (mode == 2) check(int'(in_ready), 1, "R6", "no rebuild after blocked write");
  endtask

  task automatic write_coef(input int idx, input int val);
    while (!coef_ready) tick();
    coef_we = 1'b1;
    coef_idx = 2'(idx);
    coef_val = CW'(val);
    tick();
    coef_we = 1'b0;
    cf[idx] = val;
  endtask

  // Times the rebuild after the last write while offering a junk sample (R4, R5)
  task automatic time_build();
    int n = 0;
    check(int'(in_ready), 0, "R4", "in_ready right after write");
    in_valid = 1'b1;
    in_sample = DW'(99);
    while (!in_ready && n < 100) begin
      tick();
      n++;
      if (out_valid) check(1, 0, "R5", "output during rebuild");
    end
    in_valid = 1'b0;
    check(n, 1 << NT, "R4", "rebuild length");
  endtask

  initial begin
    clear_model();
    repeat (3) tick();
    rst_n = 1'b1;
    tick();
    check(int'(out_valid), 0, "R7", "out_valid after reset");
    check(int'(in_ready), 1, "R7", "in_ready after reset");
    check(int'(coef_ready), 1, "R7", "coef_ready after reset");

    write_coef(0, 3);
    write_coef(1, -2);
    write_coef(2, 5);
    write_coef(3, 1);
    time_build();

    for (int v = 0; v < 8; v++) run_sample(VEC_X[v], 1'b1, VEC_Y[v], "R1/R8 vector", 0);

    run_sample(5, 1'b0, 0, "R3 busy sample", 1);
    run_sample(-7, 1'b0, 0, "R3 line unchanged", 0);
    run_sample(12, 1'b0, 0, "R6 old coefs", 2);
    run_sample(-40, 1'b0, 0, "R6 coefs kept", 0);

    for (int r = 0; r < 40; r++) begin
      int s;
      s = $urandom_range(255) - 128;
      run_sample(s, 1'b0, 0, "R1 random", 0);
    end

    wait_ready();
    in_valid = 1'b1;
    in_sample = DW'(55);
    coef_we = 1'b1;
    coef_idx = 2'd3;
    coef_val = CW'(-7);
    tick();
    in_valid = 1'b0;
    coef_we = 1'b0;
    cf[3] = -7;
    time_build();
    run_sample(9, 1'b0, 0, "R5 write wins", 0);

    for (int i = 0; i < NT; i++) write_coef(i, -128);
    time_build();
    for (int i = 0; i < NT; i++) run_sample(-128, 1'b0, 0, "R1 extreme", 0);
    run_sample(127, 1'b0, 0, "R1 extreme mix", 0);

    rst_n = 1'b0;
    tick();
    rst_n = 1'b1;
    clear_model();
    tick();
    check(int'(in_ready), 1, "R7", "in_ready after second reset");
    run_sample(77, 1'b1, 0, "R7 zero coefs", 0);
    run_sample(-5, 1'b1, 0, "R7 zero coefs", 0);

    finished = 1'b1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      tests++;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end
endmodule